// File: doc/BRIEF.md
# Top-of-Stack Register Cache

This block keeps the four uppermost words of a 16-bit data stack in flip-flops and keeps the deeper words in data memory. The stack grows toward higher addresses, starting just above a base address and bounded by a limit address. The execution unit issues one request at a time: push a word, pop the top word, replace the top word, or replace the top two words with one result. A binary arithmetic operation uses the last of these. The two uppermost entries are always available as operands on dedicated outputs.

The block tracks the stack position as two values. The memory pointer `sm` names the highest memory word the stack occupies, and `sm` equal to the base means no word is in memory. The 3-bit count `sr` gives how many words are cached. Their sum is the logical stack pointer. The block writes the deepest cached word out when a push meets a full cache. It reads the word at `sm` back into the bottom of the cache when a request needs more cached operands than it has. While such a memory access runs, `busy` holds off further requests. Memory uses a single-port request/acknowledge handshake that may take any number of cycles.

Top module: `tos_cache`

## Requirements
- R1: After a synchronous active-low reset, `sr` is 0, `sm` and `sp` equal `stk_base`, and `busy`, `mem_req` and both fault outputs are 0.
- R2: A push (`req_op` = 3'd1) accepted with `sr` below 4 completes without memory traffic. On the following cycle `tos` equals the pushed word, `nos` equals the previous top, and `sr` has risen by one.
- R3: A push accepted with `sr` equal to 4 first writes the deepest cached word to address `sm`+1 and increments `sm`. It then completes the push, leaving `sr` at 4.
- R4: A pop (`req_op` = 3'd2) removes the top word and lowers `sr` by one. With `sr` at 0, it first reads address `sm` into the cache and decrements `sm`.
- R5: A replace-top (`req_op` = 3'd3) overwrites `tos` with the request word and leaves the depth unchanged. With `sr` at 0, it fills one word first.
- R6: A combine (`req_op` = 3'd4) removes the two upper words and pushes the request word, so the depth drops by one. It first fills from memory, one word per access, until two words are cached.
- R7: `sp` always equals `sm` + `sr`. The cached and memory words together reproduce the logical stack contents in order.
- R8: A push that needs a spill while `sm` is at or above `stk_limit` raises `ovf_fault` for one cycle. It makes no memory access and leaves the stack unchanged.
- R9: A fill that is needed while `sm` equals `stk_base` raises `unf_fault` for one cycle and the request is dropped. Words already filled by that request stay cached.
- R10: `busy` is high from the cycle after a request that needs memory is accepted until the request completes. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. Requests presented while `busy` is high are ignored.
- R11: `req_op` values 3'd0, 3'd5, 3'd6 and 3'd7 are ignored, leaving the stack and all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present (taken when `busy` is low) |
| req_op | input | 3 | Request code: 1 push, 2 pop, 3 replace top, 4 combine top two |
| req_data | input | 16 | Word for push, replace or combine |
| busy | output | 1 | Spill or fill in progress; requests ignored |
| tos | output | 16 | Top stack word (valid when `sr` >= 1) |
| nos | output | 16 | Second stack word (valid when `sr` >= 2) |
| sr | output | 3 | Number of cached words, 0 to 4 |
| sm | output | 16 | Highest memory address occupied by the stack |
| sp | output | 16 | Logical stack pointer, `sm` + `sr` |
| stk_base | input | 16 | Stack base address (empty memory part when `sm` equals it) |
| stk_limit | input | 16 | Highest address the stack may occupy in memory |
| ovf_fault | output | 1 | One-cycle overflow indication |
| unf_fault | output | 1 | One-cycle underflow indication |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write (spill) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Spilled word |
| mem_rdata | input | 16 | Filled word, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access done |

## Verification
On every cycle, the assertions check several invariants. The cached count never exceeds four, and `sm` stays between base and limit. A write is only issued with a full cache and a read only with fewer than two cached words. The memory request stays steady until acknowledged, and it is covered by `busy`. Faults are exclusive and leave `sm` untouched. Only the bench's sweeps can show the rest. These cover data ordering across repeated spill and fill round trips, the exact `sr`/`sm` split after each request, the partial fill that precedes an underflow on a combine, and the fact that ignored and mid-busy requests leave the stack intact. A reference model of the full stack checks all of these.

// File: rtl/tosc_pkg.sv
// Shared request codes, internal register-file commands and controller states
// for the top-of-stack cache. Assumes a 3-bit request code from the execution unit.
package tosc_pkg;
    localparam logic [2:0] OP_PUSH = 3'd1;
    localparam logic [2:0] OP_POP  = 3'd2;
    localparam logic [2:0] OP_REPL = 3'd3;
    localparam logic [2:0] OP_BIN  = 3'd4;

    typedef enum logic [2:0] {
        C_HOLD, C_PUSH, C_POP, C_REPL, C_BIN, C_FILL
    } cmd_e;

    typedef enum logic [1:0] {
        S_IDLE, S_SPILL, S_FILL, S_EXEC
    } state_e;
endpackage

// File: rtl/tosc_regfile.sv
// Cached stack words. Entry 0 is the top. Applies one shift/overwrite command
// per cycle. Assumes the controller only issues commands that are legal for the
// current occupancy. Entries beyond the occupancy hold don't-care values.
module tosc_regfile
    import tosc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    localparam int IW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  cmd_e                       cmd,
    input  logic [DW-1:0]              din,
    input  logic [IW-1:0]              fill_idx,
    output logic [DEPTH-1:0][DW-1:0]   ent
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DW-1:0] from_above;
        logic [DW-1:0] from_below;

        // Neighbour values feeding this entry on push and pop shifts.
        if (g == 0) begin : g_top
            assign from_above = din;
        end else begin : g_mid
            assign from_above = ent[g-1];
        end
        if (g < DEPTH - 1) begin : g_nb
            assign from_below = ent[g+1];
        end else begin : g_bot
            assign from_below = '0;
        end

        // Per-entry update for the selected command.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else begin
                case (cmd)
                    C_PUSH: ent[g] <= from_above;
                    C_POP:  ent[g] <= from_below;
                    C_REPL: if (g == 0) ent[g] <= din;
                    C_BIN:  ent[g] <= (g == 0) ? din : from_below;
                    C_FILL: if (fill_idx == IW'(g)) ent[g] <= din;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tosc_ctrl.sv
// Sequencer for the top-of-stack cache. Owns the memory pointer and occupancy
// count, decides when to spill or fill, and raises faults. Assumes stk_base and
// stk_limit are stable while requests are in flight and that stk_base <= stk_limit.
module tosc_ctrl
    import tosc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    localparam int SRW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [DW-1:0]   req_data,
    input  logic [AW-1:0]   stk_base,
    input  logic [AW-1:0]   stk_limit,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output cmd_e            cmd,
    output logic [DW-1:0]   cmd_data,
    output logic [SRW-1:0]  sr,
    output logic [AW-1:0]   sm,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic            ovf_fault,
    output logic            unf_fault
);
    localparam logic [SRW-1:0] FULL = SRW'(DEPTH);

    state_e          st, st_n;
    logic [2:0]      pend_op, pend_op_n;
    logic [DW-1:0]   pend_data, pend_data_n;
    logic [SRW-1:0]  sr_n;
    logic [AW-1:0]   sm_n;
    logic            ovf_n, unf_n;
    logic            do_exec;
    logic [2:0]      ex_op;
    logic [DW-1:0]   ex_data;
    logic            known;

    // Cached operands each request code needs before it can execute.
    function automatic logic [SRW-1:0] need_of(input logic [2:0] op);
        case (op)
            OP_POP, OP_REPL: need_of = SRW'(1);
            OP_BIN:          need_of = SRW'(2);
            default:         need_of = '0;
        endcase
    endfunction

    assign known = req_valid && (req_op == OP_PUSH || req_op == OP_POP ||
                                 req_op == OP_REPL || req_op == OP_BIN);

    // Next-state, pointer and register-file command decision.
    always_comb begin
        st_n        = st;
        sr_n        = sr;
        sm_n        = sm;
        pend_op_n   = pend_op;
        pend_data_n = pend_data;
        ovf_n       = 1'b0;
        unf_n       = 1'b0;
        cmd         = C_HOLD;
        cmd_data    = req_data;
        do_exec     = 1'b0;
        ex_op       = pend_op;
        ex_data     = pend_data;
        case (st)
            S_IDLE: if (known) begin
                pend_op_n   = req_op;
                pend_data_n = req_data;
                ex_op       = req_op;
                ex_data     = req_data;
                if (req_op == OP_PUSH) begin
                    if (sr == FULL) begin
                        if (sm >= stk_limit) ovf_n = 1'b1;
                        else                 st_n  = S_SPILL;
                    end else begin
                        cmd  = C_PUSH;
                        sr_n = sr + 1'b1;
                    end
                end else if (sr >= need_of(req_op)) begin
                    do_exec = 1'b1;
                end else if (sm == stk_base) begin
                    unf_n = 1'b1;
                end else begin
                    st_n = S_FILL;
                end
            end
            S_SPILL: if (mem_ack) begin
                sm_n     = sm + 1'b1;
                cmd      = C_PUSH;
                cmd_data = pend_data;
                st_n     = S_IDLE;
            end
            S_FILL: if (mem_ack) begin
                cmd      = C_FILL;
                cmd_data = mem_rdata;
                sr_n     = sr + 1'b1;
                sm_n     = sm - 1'b1;
                if (({1'b0, sr} + 1'b1) >= {1'b0, need_of(pend_op)}) begin
                    st_n = S_EXEC;
                end else if ((sm - 1'b1) == stk_base) begin
                    unf_n = 1'b1;
                    st_n  = S_IDLE;
                end
            end
            S_EXEC: begin
                do_exec = 1'b1;
                st_n    = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
        if (do_exec) begin
            cmd_data = ex_data;
            case (ex_op)
                OP_POP:  begin cmd = C_POP; sr_n = sr - 1'b1; end
                OP_REPL: cmd = C_REPL;
                OP_BIN:  begin cmd = C_BIN; sr_n = sr - 1'b1; end
                default: cmd = C_HOLD;
            endcase
        end
    end

    // State, pointer, count, pending request and fault pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            sr        <= '0;
            sm        <= stk_base;
            pend_op   <= '0;
            pend_data <= '0;
            ovf_fault <= 1'b0;
            unf_fault <= 1'b0;
        end else begin
            st        <= st_n;
            sr        <= sr_n;
            sm        <= sm_n;
            pend_op   <= pend_op_n;
            pend_data <= pend_data_n;
            ovf_fault <= ovf_n;
            unf_fault <= unf_n;
        end
    end

    assign busy     = (st != S_IDLE);
    assign mem_req  = (st == S_SPILL) || (st == S_FILL);
    assign mem_we   = (st == S_SPILL);
    assign mem_addr = (st == S_SPILL) ? sm + 1'b1 : sm;
endmodule

// File: rtl/tos_cache.sv
// Top-of-stack register cache: four cached words over a memory-backed,
// upward-growing stack. Assumes one outstanding memory access at a time and a
// memory that answers every request with mem_ack eventually.
module tos_cache
    import tosc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    localparam int SRW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [DW-1:0]   req_data,
    output logic            busy,
    output logic [DW-1:0]   tos,
    output logic [DW-1:0]   nos,
    output logic [SRW-1:0]  sr,
    output logic [AW-1:0]   sm,
    output logic [AW-1:0]   sp,
    input  logic [AW-1:0]   stk_base,
    input  logic [AW-1:0]   stk_limit,
    output logic            ovf_fault,
    output logic            unf_fault,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack
);
    cmd_e                     cmd;
    logic [DW-1:0]            cmd_data;
    logic [DEPTH-1:0][DW-1:0] ent;

    tosc_ctrl #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_data(req_data),
        .stk_base(stk_base), .stk_limit(stk_limit),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cmd(cmd), .cmd_data(cmd_data), .sr(sr), .sm(sm), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .ovf_fault(ovf_fault), .unf_fault(unf_fault)
    );

    tosc_regfile #(.DW(DW), .DEPTH(DEPTH)) regs_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .din(cmd_data),
        .fill_idx(sr), .ent(ent)
    );

    assign tos       = ent[0];
    assign nos       = ent[1];
    assign mem_wdata = ent[DEPTH-1];
    assign sp        = sm + AW'(sr);
endmodule

// File: rtl/tos_cache_chk.sv
// Cycle-level properties of the top-of-stack cache, bound to every instance.
// Assumes stk_base and stk_limit are held constant after reset.
module tos_cache_chk #(
    parameter int AW  = 16,
    parameter int SRW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [SRW-1:0] sr,
    input logic [AW-1:0]  sm,
    input logic [AW-1:0]  stk_base,
    input logic [AW-1:0]  stk_limit,
    input logic           busy,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_ack,
    input logic           ovf_fault,
    input logic           unf_fault
);
    p_sr_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sr <= SRW'(4));
    p_spill_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> sr == SRW'(4));
    p_fill_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> sr < SRW'(2));
    p_sm_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sm <= stk_limit);
    p_ovf_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_fault |-> $stable(sm) && !mem_req);
    p_sm_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sm >= stk_base);
    p_fault_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_fault && unf_fault));
    p_mem_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_we) && $stable(mem_addr));
endmodule

bind tos_cache tos_cache_chk #(.AW(AW), .SRW(SRW)) chk_i (
    .clk(clk), .rst_n(rst_n), .sr(sr), .sm(sm),
    .stk_base(stk_base), .stk_limit(stk_limit), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .ovf_fault(ovf_fault), .unf_fault(unf_fault)
);

// File: tb/tos_cache_tb_top.sv
// Sweeps the top-of-stack cache through fill-to-overflow, drain-to-underflow
// and a long pseudo-random request stream against an arithmetic stack model.
module tos_cache_tb_top;
    localparam int DB = 16;
    localparam int SL = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [15:0] req_data = '0;
    logic        busy, ovf_fault, unf_fault, mem_req, mem_we;
    logic [15:0] tos, nos, sm, sp, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [2:0]  sr;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    tos_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .busy(busy), .tos(tos), .nos(nos), .sr(sr),
        .sm(sm), .sp(sp), .stk_base(16'(DB)), .stk_limit(16'(SL)),
        .ovf_fault(ovf_fault), .unf_fault(unf_fault), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Data memory model with a latency that cycles through 0..2 extra cycles.
    logic [15:0] mem [0:255];
    int lat_cnt = 0;
    int acc_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req) begin
            if (lat_cnt >= acc_cnt % 3) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:0]];
                acc_cnt <= acc_cnt + 1;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model: full logical stack plus the cached/memory split.
    logic [15:0] rs [0:63];
    int d = 0, m_sr = 0, m_sm = DB;
    bit e_ovf, e_unf, e_mem, spilled;

    task automatic model(input logic [2:0] op, input logic [15:0] data);
        int need;
        bit ok;
        e_ovf = 0; e_unf = 0; e_mem = 0; spilled = 0;
        if (op == 3'd1) begin
            if (m_sr == 4) begin
                if (m_sm >= SL) e_ovf = 1;
                else begin
                    m_sm++; spilled = 1; e_mem = 1;
                    rs[d] = data; d++;
                end
            end else begin
                m_sr++; rs[d] = data; d++;
            end
        end else if (op >= 3'd2 && op <= 3'd4) begin
            need = (op == 3'd4) ? 2 : 1;
            ok = 1;
            while (m_sr < need) begin
                if (m_sm == DB) begin e_unf = 1; ok = 0; break; end
                m_sr++; m_sm--; e_mem = 1;
            end
            if (ok) begin
                if (op == 3'd2) begin d--; m_sr--; end
                else if (op == 3'd3) rs[d-1] = data;
                else begin d--; rs[d-1] = data; m_sr--; end
            end
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd1: tag_of = "R2/R3 push";
            3'd2: tag_of = "R4 pop";
            3'd3: tag_of = "R5 replace";
            3'd4: tag_of = "R6 combine";
            default: tag_of = "R11 ignored";
        endcase
    endfunction

    // Issue one request, hold junk pushes while busy, then compare against model.
    task automatic do_op(input logic [2:0] op, input logic [15:0] data);
        bit saw_ovf, saw_unf, saw_busy;
        string t;
        t = tag_of(op);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = data;
        @(negedge clk);
        saw_busy = busy; saw_ovf = ovf_fault; saw_unf = unf_fault;
        if (busy) begin
            req_op = 3'd1; req_data = 16'hDEAD;
            while (busy) begin
                @(negedge clk);
                saw_ovf |= ovf_fault; saw_unf |= unf_fault;
            end
        end
        req_valid = 1'b0;
        model(op, data);
        chk({t, " R7 sr"}, int'(sr), m_sr);
        chk({t, " R7 sm"}, int'(sm), m_sm);
        chk({t, " R7 sp"}, int'(sp), DB + d);
        if (m_sr >= 1) chk({t, " tos"}, int'(tos), int'(rs[d-1]));
        if (m_sr >= 2) chk({t, " nos"}, int'(nos), int'(rs[d-2]));
        chk({t, " R8 ovf"}, int'(saw_ovf), int'(e_ovf));
        chk({t, " R9 unf"}, int'(saw_unf), int'(e_unf));
        chk({t, " R10 busy"}, int'(saw_busy), int'(e_mem));
        if (spilled) chk("R3 spilled word", int'(mem[m_sm[7:0]]), int'(rs[m_sm-DB-1]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sr", int'(sr), 0);
        chk("R1 sm", int'(sm), DB);
        chk("R1 sp", int'(sp), DB);
        chk("R1 busy", int'(busy), 0);
        chk("R1 mem_req", int'(mem_req), 0);
        chk("R1 faults", int'(ovf_fault | unf_fault), 0);
        // R11: unused codes on an empty and on a populated stack.
        for (int c = 0; c < 8; c++) if (c == 0 || c > 4) do_op(3'(c), 16'h1111);
        // Fill past capacity (4 cached + 8 in memory) into overflow: R2, R3, R8.
        for (int i = 0; i < 14; i++) do_op(3'd1, 16'(16'h100 + i));
        for (int c = 5; c < 8; c++) do_op(3'(c), 16'h2222);
        do_op(3'd3, 16'hABCD);
        do_op(3'd4, 16'h5A5A);
        // Drain to empty and beyond: R4, R9.
        for (int i = 0; i < 13; i++) do_op(3'd2, 16'h0);
        // Combine/replace with one or zero words stored: R5, R6, R9 partial fill.
        do_op(3'd1, 16'h0AA0);
        do_op(3'd4, 16'h0BB0);
        do_op(3'd3, 16'h0CC0);
        for (int i = 0; i < 6; i++) do_op(3'd1, 16'(16'h300 + i));
        for (int i = 0; i < 4; i++) do_op(3'd2, 16'h0);
        do_op(3'd4, 16'h0DD0);
        do_op(3'd4, 16'h0EE0);
        do_op(3'd2, 16'h0);
        do_op(3'd4, 16'h0FF0);
        do_op(3'd3, 16'h0123);
        // Pseudo-random stream over all codes.
        lfsr = 16'hACE1;
        for (int i = 0; i < 800; i++) begin
            logic [2:0] op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[3:0])
                4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: op = 3'd1;
                4'd6, 4'd7, 4'd8, 4'd9: op = 3'd2;
                4'd10, 4'd11: op = 3'd3;
                4'd12, 4'd13, 4'd14: op = 3'd4;
                default: op = lfsr[6:4];
            endcase
            do_op(op, lfsr ^ 16'h3C3C);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule